// File: doc/BRIEF.md
# Sub-Burst Interleaving Arbiter for a Shared Memory Port

This block sits in front of one memory request port that two initiators share. One of them streams: it asks for a long run of sequential words, such as a whole display line. The other is a processor whose cache-line requests need short latency. The arbiter accepts a long stream request and cuts it into fixed-size sub-bursts at consecutive addresses. Each sub-burst is offered downstream as its own valid/ready command. At every sub-burst boundary the processor can take the port instead.

The arbiter splits each address into a bank field and a row field. It compares the processor's target with the page that the stream currently has open. If the processor targets another bank, or the same row, its request goes out at the next boundary. If it targets the same bank but a different row, it would close the stream's page and force it to reopen, so the request waits. The wait lasts only up to a programmable number of sub-bursts, which keeps processor latency bounded. The sub-burst size is also programmable, and it is never allowed below the 8-word minimum efficient burst.

Top module: `burst_chop_arb`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_valid` and `cpu_req_ready` are 0 and `strm_req_ready` is 1.
- R2: An accepted stream request of L words is issued as commands with `mem_is_cpu`=0 at consecutive word addresses. Every command carries the effective chunk size except the last, which carries whatever remains.
- R3: The effective chunk size equals `cfg_chunk_words`, except that any value below 8 is raised to 8.
- R4: A processor request whose bank (address bits [12:10]) differs from the bank of the stream's next address is issued at the next sub-burst boundary.
- R5: A processor request to the same bank and the same row (address bits [26:13]) as the stream's next address is issued at the next sub-burst boundary.
- R6: A processor request to the same bank but a different row waits while exactly `cfg_defer_limit` stream sub-bursts are issued, then is issued at the following boundary. A limit of 0 means it does not wait.
- R7: A waiting processor request is issued at the first boundary after the stream's final sub-burst, even if the limit has not been reached.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, the address, length and source of the offered command do not change, and no processor request is accepted.
- R9: A stream request of length 0 is accepted and then ignored: no command appears, and `strm_req_ready` stays 1.
- R10: A processor request produces one command with `mem_is_cpu`=1, the processor's address, and a length of 8. When no stream is active, the command appears on the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chunk_words | input | 12 | Requested sub-burst size in words |
| cfg_defer_limit | input | 4 | Maximum number of sub-bursts a page-conflicting processor request waits |
| strm_req_valid | input | 1 | Stream request valid |
| strm_req_ready | output | 1 | Stream request accepted (high when no stream is active) |
| strm_req_addr | input | 32 | Stream start word address |
| strm_req_len | input | 12 | Stream length in words |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted this cycle |
| cpu_req_addr | input | 32 | Processor word address |
| mem_valid | output | 1 | Downstream command valid |
| mem_ready | input | 1 | Downstream command accepted |
| mem_addr | output | 32 | Command start word address |
| mem_len | output | 12 | Command length in words |
| mem_is_cpu | output | 1 | 1 for a processor command, 0 for a stream sub-burst |

## Verification
The assertions assume that an initiator keeps its request and address steady while valid is high and not yet accepted. They also assume that both configuration inputs stay fixed while a stream is in progress. The stimulus changes configuration only when the block is idle, and it lowers each valid only on the clock after the matching ready. The tests stall the downstream port before the processor request arrives and then release it. This makes every decision happen at a sub-burst boundary that can be predicted, so the scoreboard can list the exact order of commands for the different-bank, same-row, conflicting-row, limit-zero and stream-end cases.

// File: rtl/bca_pkg.sv
package bca_pkg;
    typedef enum logic {
        SRC_STREAM = 1'b0,
        SRC_CPU    = 1'b1
    } src_e;

    localparam int unsigned MIN_EFF_BURST = 8;
endpackage

// File: rtl/arb_addr_split.sv
module arb_addr_split #(
    parameter int unsigned AW       = 32,
    parameter int unsigned BANK_LSB = 10,
    parameter int unsigned BANK_W   = 3,
    parameter int unsigned ROW_LSB  = 13,
    parameter int unsigned ROW_W    = 14
) (
    input  logic [AW-1:0]     addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);
    always_comb begin
        bank = addr[BANK_LSB +: BANK_W];
        row  = addr[ROW_LSB +: ROW_W];
    end
endmodule

// File: rtl/arb_chunk_calc.sv
module arb_chunk_calc #(
    parameter int unsigned LW        = 12,
    parameter int unsigned MIN_BURST = 8
) (
    input  logic [LW-1:0] cfg_chunk,
    input  logic [LW-1:0] remaining,
    output logic [LW-1:0] eff_chunk,
    output logic [LW-1:0] piece_len,
    output logic          last_piece
);
    localparam logic [LW-1:0] MIN_L = LW'(MIN_BURST);

    always_comb begin
        eff_chunk  = (cfg_chunk < MIN_L) ? MIN_L : cfg_chunk;
        last_piece = (remaining <= eff_chunk);
        piece_len  = last_piece ? remaining : eff_chunk;
    end
endmodule

// File: rtl/arb_defer_ctr.sv
module arb_defer_ctr #(
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    input  logic [DW-1:0] limit,
    output logic          at_limit
);
    localparam logic [DW-1:0] SAT = {DW{1'b1}};

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump && cnt_q != SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
        at_limit = (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    clear_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/burst_chop_arb.sv
module burst_chop_arb #(
    parameter int unsigned AW       = 32,
    parameter int unsigned LW       = 12,
    parameter int unsigned DW       = 4,
    parameter int unsigned BANK_LSB = 10,
    parameter int unsigned BANK_W   = 3,
    parameter int unsigned ROW_LSB  = 13,
    parameter int unsigned ROW_W    = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_chunk_words,
    input  logic [DW-1:0] cfg_defer_limit,
    input  logic          strm_req_valid,
    output logic          strm_req_ready,
    input  logic [AW-1:0] strm_req_addr,
    input  logic [LW-1:0] strm_req_len,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic [AW-1:0] cpu_req_addr,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    output logic          mem_is_cpu
);
    import bca_pkg::*;

    localparam logic [LW-1:0] CPU_LEN = LW'(MIN_EFF_BURST);

    typedef struct packed {
        logic          active;
        logic [LW-1:0] rem;
        logic [AW-1:0] saddr;
        logic          ovalid;
        logic [AW-1:0] oaddr;
        logic [LW-1:0] olen;
        src_e          osrc;
    } st_t;

    st_t st_d, st_q;

    logic [BANK_W-1:0] s_bank, c_bank;
    logic [ROW_W-1:0]  s_row, c_row;
    logic [LW-1:0]     eff_chunk, piece_len;
    logic              last_piece;
    logic              at_limit, slot_free, conflict, cpu_go, strm_go, bump;

    arb_addr_split #(.AW(AW), .BANK_LSB(BANK_LSB), .BANK_W(BANK_W),
                     .ROW_LSB(ROW_LSB), .ROW_W(ROW_W)) u_split_strm (
        .addr(st_q.saddr), .bank(s_bank), .row(s_row));

    arb_addr_split #(.AW(AW), .BANK_LSB(BANK_LSB), .BANK_W(BANK_W),
                     .ROW_LSB(ROW_LSB), .ROW_W(ROW_W)) u_split_cpu (
        .addr(cpu_req_addr), .bank(c_bank), .row(c_row));

    arb_chunk_calc #(.LW(LW), .MIN_BURST(MIN_EFF_BURST)) u_chunk (
        .cfg_chunk(cfg_chunk_words), .remaining(st_q.rem),
        .eff_chunk(eff_chunk), .piece_len(piece_len), .last_piece(last_piece));

    arb_defer_ctr #(.DW(DW)) u_defer (
        .clk(clk), .rst_n(rst_n), .clear(cpu_go), .bump(bump),
        .limit(cfg_defer_limit), .at_limit(at_limit));

    always_comb begin
        st_d      = st_q;
        slot_free = !st_q.ovalid || mem_ready;
        conflict  = st_q.active && (c_bank == s_bank) && (c_row != s_row);
        cpu_go    = slot_free && cpu_req_valid && (!conflict || at_limit);
        strm_go   = slot_free && !cpu_go && st_q.active;
        bump      = strm_go && cpu_req_valid;

        if (slot_free) st_d.ovalid = 1'b0;

        if (cpu_go) begin
            st_d.ovalid = 1'b1;
            st_d.oaddr  = cpu_req_addr;
            st_d.olen   = CPU_LEN;
            st_d.osrc   = SRC_CPU;
        end else if (strm_go) begin
            st_d.ovalid = 1'b1;
            st_d.oaddr  = st_q.saddr;
            st_d.olen   = piece_len;
            st_d.osrc   = SRC_STREAM;
            st_d.saddr  = st_q.saddr + AW'(piece_len);
            st_d.rem    = st_q.rem - piece_len;
            if (last_piece) st_d.active = 1'b0;
        end

        if (!st_q.active && strm_req_valid) begin
            st_d.active = (strm_req_len != '0);
            st_d.rem    = strm_req_len;
            st_d.saddr  = strm_req_addr;
        end

        strm_req_ready = !st_q.active;
        cpu_req_ready  = cpu_go;
        mem_valid      = st_q.ovalid;
        mem_addr       = st_q.oaddr;
        mem_len        = st_q.olen;
        mem_is_cpu     = (st_q.osrc == SRC_CPU);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, rem: '0, saddr: '0, ovalid: 1'b0,
                      oaddr: '0, olen: '0, osrc: SRC_STREAM};
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_len) && $stable(mem_is_cpu)));

    // R8
    no_cpu_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |-> !cpu_req_ready);

    // R10
    cpu_cmd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> (mem_valid && mem_is_cpu
                                              && mem_len == CPU_LEN));

    // R2
    strm_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_is_cpu) |-> (mem_len != '0));

    // R6
    limit_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && at_limit && (!mem_valid || mem_ready)) |-> cpu_req_ready);

    // R9
    zero_len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_req_valid && strm_req_ready && strm_req_len == '0) |=> strm_req_ready);
endmodule

// File: tb/burst_chop_arb_test.sv
module burst_chop_arb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_chunk_words = 12'd16;
    logic [3:0]  cfg_defer_limit = 4'd2;
    logic        strm_req_valid = 1'b0;
    logic [31:0] strm_req_addr = '0;
    logic [11:0] strm_req_len = '0;
    logic        cpu_req_valid = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic        mem_ready = 1'b0;
    logic        strm_req_ready, cpu_req_ready, mem_valid, mem_is_cpu;
    logic [31:0] mem_addr;
    logic [11:0] mem_len;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [44:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    burst_chop_arb uut (
        .clk(clk), .rst_n(rst_n), .cfg_chunk_words(cfg_chunk_words),
        .cfg_defer_limit(cfg_defer_limit), .strm_req_valid(strm_req_valid),
        .strm_req_ready(strm_req_ready), .strm_req_addr(strm_req_addr),
        .strm_req_len(strm_req_len), .cpu_req_valid(cpu_req_valid),
        .cpu_req_ready(cpu_req_ready), .cpu_req_addr(cpu_req_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_is_cpu(mem_is_cpu));

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_exp(input bit is_cpu, input logic [31:0] a,
                            input logic [11:0] l, input string req);
        exp_q.push_back({is_cpu, a, l});
        tag_q.push_back(req);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected command", 64'({mem_is_cpu, mem_addr, mem_len}), 64'd0);
            end else begin
                logic [44:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({mem_is_cpu, mem_addr, mem_len} == e, t,
                      64'({mem_is_cpu, mem_addr, mem_len}), 64'(e));
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "watchdog", 64'(cycles), 64'd20000);
            finish_run();
        end
    end

    task automatic drain(input string req);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !mem_valid) break;
        end
        check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    endtask

    // stall the port, start a stream, bring a CPU request, release
    task automatic run_case(input logic [31:0] sa, input logic [11:0] sl,
                            input logic [11:0] chunk, input logic [3:0] lim,
                            input bit use_cpu, input logic [31:0] ca, input string req);
        @(posedge clk); #1;
        mem_ready = 1'b0;
        cfg_chunk_words = chunk;
        cfg_defer_limit = lim;
        strm_req_addr = sa;
        strm_req_len = sl;
        strm_req_valid = 1'b1;
        @(posedge clk); #1;
        strm_req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        if (use_cpu) begin
            cpu_req_addr = ca;
            cpu_req_valid = 1'b1;
        end
        @(negedge clk);
        begin
            logic [31:0] held;
            held = mem_addr;
            check(mem_valid && !cpu_req_ready, "R8 stalled offer", 64'({mem_valid, cpu_req_ready}), 64'b10);
            @(negedge clk);
            check(mem_addr == held, "R8 held address", 64'(mem_addr), 64'(held));
        end
        @(posedge clk); #1;
        mem_ready = 1'b1;
        if (use_cpu) begin
            #1;
            while (!cpu_req_ready) begin
                @(posedge clk); #2;
            end
            @(posedge clk); #1;
            cpu_req_valid = 1'b0;
        end
        drain(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!mem_valid && !cpu_req_ready && strm_req_ready, "R1 in reset",
              64'({mem_valid, cpu_req_ready, strm_req_ready}), 64'b001);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_valid && !cpu_req_ready && strm_req_ready, "R1 after reset",
              64'({mem_valid, cpu_req_ready, strm_req_ready}), 64'b001);

        // R4: different bank interleaves at the first boundary
        push_exp(0, 32'h0, 12'd16, "R4 s0");
        push_exp(1, 32'h400, 12'd8, "R4 cpu");
        push_exp(0, 32'h10, 12'd16, "R4 s1");
        push_exp(0, 32'h20, 12'd16, "R4 s2");
        push_exp(0, 32'h30, 12'd16, "R4 s3");
        run_case(32'h0, 12'd64, 12'd16, 4'd2, 1, 32'h400, "R4 drain");

        // R5: same bank, same row
        push_exp(0, 32'h0, 12'd16, "R5 s0");
        push_exp(1, 32'h100, 12'd8, "R5 cpu");
        push_exp(0, 32'h10, 12'd16, "R5 s1");
        run_case(32'h0, 12'd32, 12'd16, 4'd2, 1, 32'h100, "R5 drain");

        // R6: same bank, other row, limit 2
        push_exp(0, 32'h0, 12'd16, "R6 s0");
        push_exp(0, 32'h10, 12'd16, "R6 s1 deferred");
        push_exp(0, 32'h20, 12'd16, "R6 s2 deferred");
        push_exp(1, 32'h2000, 12'd8, "R6 cpu at limit");
        push_exp(0, 32'h30, 12'd16, "R6 s3");
        push_exp(0, 32'h40, 12'd16, "R6 s4");
        push_exp(0, 32'h50, 12'd16, "R6 s5");
        run_case(32'h0, 12'd96, 12'd16, 4'd2, 1, 32'h2000, "R6 drain");

        // R6: limit 0 means no deferral
        push_exp(0, 32'h0, 12'd16, "R6 lim0 s0");
        push_exp(1, 32'h2000, 12'd8, "R6 lim0 cpu");
        push_exp(0, 32'h10, 12'd16, "R6 lim0 s1");
        run_case(32'h0, 12'd32, 12'd16, 4'd0, 1, 32'h2000, "R6 lim0 drain");

        // R7: stream ends before the limit
        push_exp(0, 32'h0, 12'd16, "R7 s0");
        push_exp(0, 32'h10, 12'd16, "R7 s1");
        push_exp(1, 32'h2000, 12'd8, "R7 cpu after end");
        run_case(32'h0, 12'd32, 12'd16, 4'd5, 1, 32'h2000, "R7 drain");

        // R3: chunk below minimum raised to 8, remainder last (R2)
        push_exp(0, 32'h800, 12'd8, "R3 s0");
        push_exp(0, 32'h808, 12'd8, "R3 s1");
        push_exp(0, 32'h810, 12'd4, "R2 remainder");
        run_case(32'h800, 12'd20, 12'd3, 4'd1, 0, 32'h0, "R3 drain");

        // R9: zero-length stream ignored
        @(posedge clk); #1;
        strm_req_addr = 32'h40;
        strm_req_len = 12'd0;
        strm_req_valid = 1'b1;
        @(posedge clk); #1;
        strm_req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!mem_valid && strm_req_ready, "R9 zero length",
                  64'({mem_valid, strm_req_ready}), 64'b01);
        end

        // R10: idle CPU goes straight through
        push_exp(1, 32'h1234, 12'd8, "R10 idle cpu");
        @(posedge clk); #1;
        cpu_req_addr = 32'h1234;
        cpu_req_valid = 1'b1;
        #1;
        check(cpu_req_ready, "R10 accept idle", 64'(cpu_req_ready), 64'd1);
        @(posedge clk); #1;
        cpu_req_valid = 1'b0;
        drain("R10 drain");

        finish_run();
    end
endmodule